// File: doc/BRIEF.md
# Selectable Three-Mode Digital Phase Detector

This block compares a reference signal with feedback from an oscillator or divider and produces an error signal for a loop filter. It runs on a fast sampling clock, and both inputs are asynchronous logic levels. Inside the block each input goes through a two-flop synchronizer and then a rising-edge detector. A two-bit select chooses one of three detector styles, and all three share the same pair of inputs.

The exclusive-OR style gives a duty-cycle error that depends on the phase difference. The edge style is a phase-frequency detector. Its three-state pump output is modelled as an enable and a level. It also has a lock flag that is high while no correction is pending. The set-reset style sets on reference edges and clears on feedback edges.

An inhibit input quiets every output. Changing the select starts the newly chosen detector from a clean state.

Top module: `tri_mode_phase_detector`

## Requirements
- R1: With `mode_sel`=0 (exclusive-OR), `xor_out` equals the exclusive-OR of the synchronized inputs. It is low for inputs in phase and high all the time for inputs 180 degrees apart.
- R2: With `mode_sel`=1 (edge), falling edges have no effect. Results depend only on rising-edge positions, whatever the duty cycle.
- R3: In edge mode, a reference rise while idle makes the pump drive high (`pump_en`=1, `pump_lvl`=1). The drive lasts until the next feedback rise, and the pump then returns to high impedance (`pump_en`=0).
- R4: In edge mode, a feedback rise while idle makes the pump drive low (`pump_en`=1, `pump_lvl`=0). The drive lasts until the next reference rise, and the pump then returns to high impedance.
- R5: `lock` is 1 exactly when `pump_en` is 0.
- R6: With the reference held still, feedback edges alone keep the pump driving low indefinitely.
- R7: Extra reference rises while the pump drives high are ignored. The drive stays high until a feedback rise.
- R8: With `mode_sel`=2 (set-reset), a reference rise sets `sr_out` and a feedback rise clears it. Repeated rises on the same input change nothing.
- R9: When both inputs rise in the same sampling cycle, neither the edge-mode state nor the set-reset state changes.
- R10: An input change that is stable before clock edge k shows at the outputs right after edge k+2, which is three sampling clocks.
- R11: A synchronous reset (`rst`=1) gives `pump_en`=0, `lock`=1, `sr_out`=0 and `xor_out`=0.
- R12: Outputs of the modes that are not selected are held idle: `xor_out`=0, `pump_en`=0, `sr_out`=0. `mode_sel`=3 selects none of the modes. Any change of `mode_sel` clears the detector state, and the new mode acts from the following cycle.
- R13: While `inhibit`=1, from the next clock on `xor_out`=0, `pump_en`=0, `lock`=1 and `sr_out`=0, and the detector state is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| inhibit | input | 1 | Forces all detector outputs quiet |
| mode_sel | input | 2 | 0 XOR, 1 edge, 2 set-reset, 3 none |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback signal |
| xor_out | output | 1 | Exclusive-OR detector output |
| pump_en | output | 1 | Edge detector drive enable (0 = high impedance) |
| pump_lvl | output | 1 | Edge detector drive level when enabled |
| lock | output | 1 | High while no edge-mode correction is pending |
| sr_out | output | 1 | Set-reset detector output |

## Verification
A wrong edge-mode state shows up as a pump that drives when it should float, or that keeps driving past the releasing edge. Because state feeds the outputs through no further register, the error is visible in the cycle after the faulty transition. A lost set-reset state, or a missed clear on a mode change or on inhibit, shows on `sr_out` or `pump_en` one clock after the event. A synchronizer that is off by a stage shifts every response by one cycle, so the exact three-clock latency check exposes it.

// File: rtl/pdet_pkg.sv
package pdet_pkg;

    typedef enum logic [1:0] {
        PD_MODE_XOR  = 2'd0,
        PD_MODE_EDGE = 2'd1,
        PD_MODE_SR   = 2'd2,
        PD_MODE_OFF  = 2'd3
    } pd_mode_e;

    typedef enum logic [1:0] {
        PUMP_HIZ = 2'd0,
        PUMP_UP  = 2'd1,
        PUMP_DN  = 2'd2
    } pump_state_e;

    typedef struct packed {
        logic level;
        logic rise;
    } edge_info_t;

    // Next pump state: only a lone rising edge can move the machine.
    function automatic pump_state_e pump_next(pump_state_e cur, logic r_rise, logic f_rise);
        pump_state_e nxt;
        nxt = cur;
        if (r_rise != f_rise) begin
            unique case (cur)
                PUMP_HIZ: nxt = r_rise ? PUMP_UP : PUMP_DN;
                PUMP_UP:  nxt = f_rise ? PUMP_HIZ : PUMP_UP;
                PUMP_DN:  nxt = r_rise ? PUMP_HIZ : PUMP_DN;
                default:  nxt = PUMP_HIZ;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/pdet_sync_edge.sv
module pdet_sync_edge
    import pdet_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    output edge_info_t info
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign info.level = chain[LAST];
    assign info.rise  = chain[LAST] & ~chain[STAGES];

    initial begin
        if (STAGES < 2) $error("pdet_sync_edge needs at least two stages");
    end
endmodule

// File: rtl/pdet_pfd.sv
module pdet_pfd
    import pdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  edge_info_t ref_e,
    input  edge_info_t fb_e,
    output logic       pump_en,
    output logic       pump_lvl,
    output logic       lock
);
    pump_state_e state;

    always_ff @(posedge clk) begin
        if (rst || !enable) state <= PUMP_HIZ;
        else                state <= pump_next(state, ref_e.rise, fb_e.rise);
    end

    assign pump_en  = (state != PUMP_HIZ);
    assign pump_lvl = (state == PUMP_UP);
    assign lock     = (state == PUMP_HIZ);

    AST_UP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (enable && state == PUMP_UP && fb_e.rise && !ref_e.rise) |=> state == PUMP_HIZ); // R3
    AST_DN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (enable && state == PUMP_DN && ref_e.rise && !fb_e.rise) |=> state == PUMP_HIZ); // R4
    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (enable && state == PUMP_UP && !fb_e.rise) |=> state == PUMP_UP); // R7
    AST_SIMUL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (enable && ref_e.rise && fb_e.rise) |=> $stable(state)); // R9
endmodule

// File: rtl/pdet_srff.sv
module pdet_srff
    import pdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  edge_info_t ref_e,
    input  edge_info_t fb_e,
    output logic       q
);
    always_ff @(posedge clk) begin
        if (rst || !enable)              q <= 1'b0;
        else if (ref_e.rise && !fb_e.rise) q <= 1'b1;
        else if (fb_e.rise && !ref_e.rise) q <= 1'b0;
    end

    AST_SR_SET: assert property (@(posedge clk) disable iff (rst)
        (enable && ref_e.rise && !fb_e.rise) |=> q); // R8
    AST_SR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (enable && fb_e.rise && !ref_e.rise) |=> !q); // R8
    AST_SR_SIMUL: assert property (@(posedge clk) disable iff (rst)
        (enable && ref_e.rise && fb_e.rise) |=> $stable(q)); // R9
endmodule

// File: rtl/tri_mode_phase_detector.sv
module tri_mode_phase_detector
    import pdet_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inhibit,
    input  logic [1:0] mode_sel,
    input  logic       ref_in,
    input  logic       fb_in,
    output logic       xor_out,
    output logic       pump_en,
    output logic       pump_lvl,
    output logic       lock,
    output logic       sr_out
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in;
    edge_info_t     chan [NCH];
    edge_info_t     ref_e, fb_e;

    assign raw_in = {fb_in, ref_in};

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_sync
            pdet_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_in[i]),
                .info (chan[i])
            );
        end
    endgenerate

    assign ref_e = chan[0];
    assign fb_e  = chan[1];

    pd_mode_e mode_now, mode_q;
    logic     mode_steady;

    assign mode_now    = pd_mode_e'(mode_sel);
    assign mode_steady = (mode_now == mode_q) && !inhibit;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PD_MODE_XOR;
        else     mode_q <= mode_now;
    end

    always_ff @(posedge clk) begin
        if (rst) xor_out <= 1'b0;
        else     xor_out <= (mode_steady && mode_now == PD_MODE_XOR) ? (ref_e.level ^ fb_e.level) : 1'b0;
    end

    pdet_pfd u_pfd (
        .clk      (clk),
        .rst      (rst),
        .enable   (mode_steady && mode_now == PD_MODE_EDGE),
        .ref_e    (ref_e),
        .fb_e     (fb_e),
        .pump_en  (pump_en),
        .pump_lvl (pump_lvl),
        .lock     (lock)
    );

    pdet_srff u_sr (
        .clk    (clk),
        .rst    (rst),
        .enable (mode_steady && mode_now == PD_MODE_SR),
        .ref_e  (ref_e),
        .fb_e   (fb_e),
        .q      (sr_out)
    );

    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (!xor_out && !pump_en && lock && !sr_out)); // R13
    AST_PUMP_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'd1) |=> !pump_en); // R12
    AST_SR_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'd2) |=> !sr_out); // R12
    AST_XOR_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'd0) |=> !xor_out); // R12
    AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (rst)
        lock != pump_en); // R5
endmodule

// File: tb/tri_mode_phase_detector_test.sv
`timescale 1ns/1ps
module tri_mode_phase_detector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inhibit = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       xor_out, pump_en, pump_lvl, lock, sr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tri_mode_phase_detector uut (
        .clk(clk), .rst(rst), .inhibit(inhibit), .mode_sel(mode_sel),
        .ref_in(ref_in), .fb_in(fb_in), .xor_out(xor_out), .pump_en(pump_en),
        .pump_lvl(pump_lvl), .lock(lock), .sr_out(sr_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference model: input history and a pump state code
    // 0 = floating, 1 = driving high, 2 = driving low.
    int  hr[3], hf[3];
    int  m_pump = 0;
    int  m_sr = 0;
    int  m_xor = 0;
    int  m_prev = 0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (hr[i]) begin hr[i] = 0; hf[i] = 0; end
            m_pump = 0; m_sr = 0; m_xor = 0; m_prev = 0;
        end else begin
            int  md;
            bit  ok_mode, rr, fr;
            md = int'(mode_sel);
            ok_mode = !inhibit && (md == m_prev);
            rr = (hr[1] == 1) && (hr[2] == 0);
            fr = (hf[1] == 1) && (hf[2] == 0);
            m_xor = (ok_mode && md == 0) ? (hr[1] ^ hf[1]) : 0;
            if (ok_mode && md == 1) begin
                if (rr && !fr) m_pump = (m_pump == 0) ? 1 : (m_pump == 2 ? 0 : 1);
                else if (fr && !rr) m_pump = (m_pump == 0) ? 2 : (m_pump == 1 ? 0 : 2);
            end else m_pump = 0;
            if (ok_mode && md == 2) begin
                if (rr && !fr) m_sr = 1;
                else if (fr && !rr) m_sr = 0;
            end else m_sr = 0;
            m_prev = md;
            hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = int'(ref_in);
            hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = int'(fb_in);
        end
    end

    always @(posedge clk) begin
        #2;
        if (!finished) begin
            check(int'(xor_out) == m_xor, "R1 xor_out", int'(xor_out), m_xor);
            check(int'(pump_en) == (m_pump != 0), "R3 pump_en", int'(pump_en), int'(m_pump != 0));
            if (m_pump != 0)
                check(int'(pump_lvl) == (m_pump == 1), "R4 pump_lvl", int'(pump_lvl), int'(m_pump == 1));
            check(int'(lock) == (m_pump == 0), "R5 lock", int'(lock), int'(m_pump == 0));
            check(int'(sr_out) == m_sr, "R8 sr_out", int'(sr_out), m_sr);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Square waves with given half periods and phase offsets.
    task automatic waves(input int n, input int rper, input int fper, input int foff, input bit ref_on);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (ref_on) ref_in = ((t / rper) % 2) == 1;
            fb_in = (((t + foff) / fper) % 2) == 1;
        end
    endtask

    initial begin
        tick(3);
        check(pump_en == 0 && lock == 1 && sr_out == 0 && xor_out == 0, "R11 reset state",
              {pump_en, lock, sr_out, xor_out}, 4'b0100);
        rst = 1'b0;
        tick(2);

        // R10: three-clock latency in XOR mode
        ref_in = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        check(xor_out == 0, "R10 before third edge", xor_out, 0);
        @(posedge clk); #2;
        check(xor_out == 1, "R10 at third edge", xor_out, 1);
        tick(1); ref_in = 1'b0; tick(4);

        // R1: in phase then 180 apart
        waves(40, 5, 5, 0, 1);
        waves(40, 5, 5, 5, 1);
        tick(2);
        check(xor_out == 1, "R1 antiphase constant high", xor_out, 1);

        // Edge mode
        mode_sel = 2'd1; ref_in = 0; fb_in = 0; tick(4);
        waves(60, 6, 6, 2, 1);
        waves(60, 6, 7, 0, 1);
        waves(60, 3, 8, 0, 1);             // R2 varied duty and rates
        // R3: ref rise from idle
        ref_in = 0; fb_in = 0; tick(6);
        ref_in = 1; tick(5);
        check(pump_en == 1 && pump_lvl == 1, "R3 drive high", {pump_en, pump_lvl}, 2'b11);
        // R7: extra reference edges ignored
        ref_in = 0; tick(2); ref_in = 1; tick(2); ref_in = 0; tick(2); ref_in = 1; tick(4);
        check(pump_en == 1 && pump_lvl == 1, "R7 stays high", {pump_en, pump_lvl}, 2'b11);
        // R2: falling feedback edge no effect
        fb_in = 1; tick(1); fb_in = 0; tick(1);   // rise then fall: rise releases
        tick(4);
        check(pump_en == 0, "R3 release on feedback", pump_en, 0);
        fb_in = 1; tick(5);
        check(pump_en == 1 && pump_lvl == 0, "R4 drive low", {pump_en, pump_lvl}, 2'b10);
        fb_in = 0; tick(5);
        check(pump_en == 1 && pump_lvl == 0, "R2 falling edge ignored", {pump_en, pump_lvl}, 2'b10);
        // R6: reference absent, feedback toggling
        ref_in = 0;
        waves(80, 4, 4, 0, 0);
        check(pump_en == 1 && pump_lvl == 0 && lock == 0, "R6 absent ref drives low",
              {pump_en, pump_lvl, lock}, 3'b100);
        ref_in = 1; tick(5);
        check(pump_en == 0 && lock == 1, "R4 release on reference", {pump_en, lock}, 2'b01);
        // R9: simultaneous rises from idle
        ref_in = 0; fb_in = 0; tick(5);
        ref_in = 1; fb_in = 1; tick(6);
        check(pump_en == 0 && lock == 1, "R9 simultaneous edges", {pump_en, lock}, 2'b01);

        // R12: mode change clears pending drive
        ref_in = 0; fb_in = 0; tick(5); ref_in = 1; tick(5);
        mode_sel = 2'd3; tick(1);
        check(pump_en == 0 && sr_out == 0 && xor_out == 0, "R12 mode off quiet",
              {pump_en, sr_out, xor_out}, 0);
        mode_sel = 2'd1; tick(4);
        check(pump_en == 0, "R12 state cleared after switch", pump_en, 0);

        // Set-reset mode
        mode_sel = 2'd2; ref_in = 0; fb_in = 0; tick(4);
        ref_in = 1; tick(5);
        check(sr_out == 1, "R8 set", sr_out, 1);
        ref_in = 0; tick(2); ref_in = 1; tick(4);
        check(sr_out == 1, "R8 repeated set", sr_out, 1);
        fb_in = 1; tick(5);
        check(sr_out == 0, "R8 clear", sr_out, 0);
        ref_in = 0; fb_in = 0; tick(3); ref_in = 1; fb_in = 1; tick(5);
        check(sr_out == 0, "R9 simultaneous in set-reset", sr_out, 0);
        ref_in = 0; fb_in = 0;
        waves(80, 5, 6, 3, 1);

        // R13: inhibit
        mode_sel = 2'd1; ref_in = 0; fb_in = 0; tick(4); ref_in = 1; tick(5);
        inhibit = 1; tick(1);
        check(pump_en == 0 && lock == 1 && sr_out == 0 && xor_out == 0, "R13 inhibit quiet",
              {pump_en, lock, sr_out, xor_out}, 4'b0100);
        fb_in = 1; tick(6);
        check(pump_en == 0, "R13 held during inhibit", pump_en, 0);
        inhibit = 0; ref_in = 0; fb_in = 0; tick(4);
        waves(60, 4, 5, 1, 1);

        // R11: reset mid-drive
        ref_in = 0; fb_in = 0; tick(4); ref_in = 1; tick(5);
        rst = 1; tick(1);
        check(pump_en == 0 && lock == 1, "R11 reset releases pump", {pump_en, lock}, 2'b01);
        rst = 0; tick(4);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule